// File: doc/BRIEF.md
# Flag-Generating Adder/Subtractor

This block is a combinational adder/subtractor with a configurable width. It performs four operations on a single adder: plain add, add with the stored carry, plain subtract, and subtract with the stored borrow. Subtraction uses the same adder: the second operand is inverted and the adder's carry-in is set. In that mode the reported carry flag is the complement of the adder's carry out, so it reads as a borrow.

Next to the result, the unit produces four condition flags: carry/borrow, negative, zero and signed overflow. It also gives an unsigned overflow flag for additions and an unsigned underflow flag for subtractions. A parameter selects whether the four condition flags are also held in a register stage. That stage loads when an enable input is high and clears on reset. Without it, the held-flag outputs simply follow the combinational flags.

Top module: `addsub_flags`

## Requirements
- R1: With `op` = 2'b00 (ADD), `res` equals (A + B) mod 2^W, and the value on `cf_in` has no effect on any output.
- R2: With `op` = 2'b01 (ADC), `res` equals (A + B + `cf_in`) mod 2^W.
- R3: With `op` = 2'b10 (SUB), `res` equals (A − B) mod 2^W, and the value on `cf_in` has no effect on any output.
- R4: With `op` = 2'b11 (SBC), `cf_in` is read as a pending borrow, and `res` equals (A − B − `cf_in`) mod 2^W.
- R5: For add operations, `c_flag` and `uns_ovf` are 1 exactly when the true unsigned sum is 2^W or more. For subtract operations, `c_flag` and `uns_unf` are 1 exactly when the true unsigned difference is below zero. `uns_ovf` is always 0 on subtracts, and `uns_unf` is always 0 on adds.
- R6: `v_flag` is 1 exactly when the two's-complement result of the operation does not fit in W bits.
- R7: `n_flag` equals bit W−1 of `res`, and `z_flag` is 1 exactly when every bit of `res` is 0.
- R8: At W = 4, these cases hold:
  - 4 + 4 gives C = 0 and V = 1.
  - 8 + 8 gives C = 1, V = 1 and a result of 0000.
  - 5 − 0 gives 0101 with no borrow.
- R9: When the register stage is enabled, `q_c`, `q_n`, `q_z` and `q_v` clear to 0 on reset. On a rising clock edge with `flag_en` high, they load `c_flag`, `n_flag`, `z_flag` and `v_flag`. With `flag_en` low, they keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register stage |
| rst_n | input | 1 | Active-low reset for the flag register stage |
| flag_en | input | 1 | Loads the held flags on the next rising edge |
| op | input | 2 | Operation: 00 ADD, 01 ADC, 10 SUB, 11 SBC |
| a | input | W | First operand |
| b | input | W | Second operand |
| cf_in | input | 1 | Stored carry (ADC) or borrow (SBC) |
| res | output | W | Result |
| c_flag | output | 1 | Carry on add, borrow on subtract |
| n_flag | output | 1 | Result MSB |
| z_flag | output | 1 | Result is zero |
| v_flag | output | 1 | Signed overflow |
| uns_ovf | output | 1 | Unsigned overflow on add |
| uns_unf | output | 1 | Unsigned underflow on subtract |
| q_c | output | 1 | Held carry/borrow flag |
| q_n | output | 1 | Held negative flag |
| q_z | output | 1 | Held zero flag |
| q_v | output | 1 | Held overflow flag |

## Verification
The bench builds two copies of the block.

The first copy is 4 bits wide with the register stage present. The bench sweeps every operand pair, every opcode and both values of the stored flag through it. At this width every carry boundary, every sign-crossing case and every zero result is reached, so each operation's corner cases are covered completely. The held flags are checked after every vector.

The second copy is 16 bits wide with no register stage. The bench applies random vectors to it to confirm that the carry chain and the flags behave the same at the default width.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W = 16,
  parameter bit REG_FLAGS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_en,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cf_in,
  output logic [W-1:0] res,
  output logic         c_flag,
  output logic         n_flag,
  output logic         z_flag,
  output logic         v_flag,
  output logic         uns_ovf,
  output logic         uns_unf,
  output logic         q_c,
  output logic         q_n,
  output logic         q_z,
  output logic         q_v
);
  localparam int M = W - 1;

  logic         is_sub;
  logic         cin;
  logic [W-1:0] bx;
  logic [M:0]   lo_sum;
  logic         c_msb, cout, v_alt;

  assign is_sub = op[1];
  assign bx     = is_sub ? ~b : b;

  always_comb begin
    case (op)
      2'b00:   cin = 1'b0;
      2'b01:   cin = cf_in;
      2'b10:   cin = 1'b1;
      default: cin = ~cf_in;
    endcase
  end

  assign lo_sum = {1'b0, a[M-1:0]} + {1'b0, bx[M-1:0]} + {{M{1'b0}}, cin};
  assign c_msb  = lo_sum[M];
  assign res    = {a[M] ^ bx[M] ^ c_msb, lo_sum[M-1:0]};
  assign cout   = (a[M] & bx[M]) | (c_msb & (a[M] ^ bx[M]));

  assign c_flag  = is_sub ? ~cout : cout;
  assign v_flag  = c_msb ^ cout;
  assign n_flag  = res[M];
  assign z_flag  = ~|res;
  assign uns_ovf = ~is_sub & cout;
  assign uns_unf = is_sub & ~cout;

  assign v_alt = is_sub ? ((a[M] != b[M]) && (res[M] == b[M]))
                        : ((a[M] == b[M]) && (res[M] != a[M]));

  a_r6_ovf_methods_agree: assert property (@(posedge clk) disable iff (!rst_n)
    v_flag == v_alt);
  a_r5_ovf_unf_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(uns_ovf && uns_unf));
  a_r7_zero_not_negative: assert property (@(posedge clk) disable iff (!rst_n)
    z_flag |-> !n_flag);

  generate
    if (REG_FLAGS) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_c <= 1'b0; q_n <= 1'b0; q_z <= 1'b0; q_v <= 1'b0;
        end else if (flag_en) begin
          q_c <= c_flag; q_n <= n_flag; q_z <= z_flag; q_v <= v_flag;
        end
      end

      a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> (q_c == $past(c_flag)) && (q_n == $past(n_flag)) &&
                    (q_z == $past(z_flag)) && (q_v == $past(v_flag)));
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable(q_c) && $stable(q_n) && $stable(q_z) && $stable(q_v));
    end else begin : g_comb
      assign q_c = c_flag;
      assign q_n = n_flag;
      assign q_z = z_flag;
      assign q_v = v_flag;
    end
  endgenerate
endmodule

// File: tb/sim_addsub_flags.sv
module sim_addsub_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [1:0] op0 = '0, op1 = '0;
  logic [3:0] a0 = '0, b0 = '0;
  logic [15:0] a1 = '0, b1 = '0;
  logic cf0 = 1'b0, cf1 = 1'b0, en0 = 1'b0;
  logic [3:0] r0;
  logic [15:0] r1;
  logic c0, n0, z0, v0, uo0, uu0, qc0, qn0, qz0, qv0;
  logic c1, n1, z1, v1, uo1, uu1, qc1, qn1, qz1, qv1;

  addsub_flags #(.W(4), .REG_FLAGS(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .flag_en(en0), .op(op0), .a(a0), .b(b0), .cf_in(cf0),
    .res(r0), .c_flag(c0), .n_flag(n0), .z_flag(z0), .v_flag(v0),
    .uns_ovf(uo0), .uns_unf(uu0), .q_c(qc0), .q_n(qn0), .q_z(qz0), .q_v(qv0));

  addsub_flags #(.W(16), .REG_FLAGS(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .flag_en(1'b0), .op(op1), .a(a1), .b(b1), .cf_in(cf1),
    .res(r1), .c_flag(c1), .n_flag(n1), .z_flag(z1), .v_flag(v1),
    .uns_ovf(uo1), .uns_unf(uu1), .q_c(qc1), .q_n(qn1), .q_z(qz1), .q_v(qv1));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic model(input int w, input int a, input int b, input int op, input int cf,
                       output int r, output int c, output int n, output int z,
                       output int v, output int uo, output int uu);
    int md, half, sa, sb, s, t, ci;
    md = 1 << w; half = md / 2;
    sa = (a >= half) ? a - md : a;
    sb = (b >= half) ? b - md : b;
    if (op < 2) begin
      ci = (op == 1) ? cf : 0;
      t = a + b + ci; s = sa + sb + ci;
      r = t % md; c = (t >= md) ? 1 : 0; uo = c; uu = 0;
    end else begin
      ci = (op == 3) ? cf : 0;
      t = a - b - ci; s = sa - sb - ci;
      r = (t + md) % md; c = (t < 0) ? 1 : 0; uo = 0; uu = c;
    end
    v = (s >= half || s < -half) ? 1 : 0;
    n = (r >= half) ? 1 : 0;
    z = (r == 0) ? 1 : 0;
  endtask

  function automatic string rtag(input int op);
    case (op)
      0: return "R1 ADD res";
      1: return "R2 ADC res";
      2: return "R3 SUB res";
      default: return "R4 SBC res";
    endcase
  endfunction

  int er, ec, en, ez, ev, eo, eu;

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset q_c", qc0, 0); chk("R9 reset q_n", qn0, 0);
    chk("R9 reset q_z", qz0, 0); chk("R9 reset q_v", qv0, 0);
    rst_n = 1'b1;

    for (int op = 0; op < 4; op++)
      for (int cf = 0; cf < 2; cf++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            op0 = op[1:0]; cf0 = cf[0]; a0 = a[3:0]; b0 = b[3:0]; en0 = 1'b1;
            model(4, a, b, op, cf, er, ec, en, ez, ev, eo, eu);
            #5;
            chk(rtag(op), int'(r0), er);
            chk("R5 c_flag", int'(c0), ec);
            chk("R5 uns_ovf", int'(uo0), eo);
            chk("R5 uns_unf", int'(uu0), eu);
            chk("R6 v_flag", int'(v0), ev);
            chk("R7 n_flag", int'(n0), en);
            chk("R7 z_flag", int'(z0), ez);
            @(posedge clk); #1;
            chk("R9 q_c load", int'(qc0), ec);
            chk("R9 q_n load", int'(qn0), en);
            chk("R9 q_z load", int'(qz0), ez);
            chk("R9 q_v load", int'(qv0), ev);
          end

    // R8 directed cases; 4+4 is captured into the held flags
    @(negedge clk); op0 = 2'b00; cf0 = 1'b1; a0 = 4'd4; b0 = 4'd4; en0 = 1'b1; #5;
    chk("R8 4+4 C", int'(c0), 0); chk("R8 4+4 V", int'(v0), 1);
    @(negedge clk); op0 = 2'b00; cf0 = 1'b0; a0 = 4'd8; b0 = 4'd8; en0 = 1'b0; #5;
    chk("R8 8+8 C", int'(c0), 1); chk("R8 8+8 res", int'(r0), 0);
    chk("R8 8+8 V", int'(v0), 1);
    @(posedge clk); #1;
    chk("R9 hold q_c", int'(qc0), 0); chk("R9 hold q_n", int'(qn0), 1);
    chk("R9 hold q_z", int'(qz0), 0); chk("R9 hold q_v", int'(qv0), 1);
    @(negedge clk); op0 = 2'b10; cf0 = 1'b1; a0 = 4'd5; b0 = 4'd0; #5;
    chk("R8 5-0 res", int'(r0), 5); chk("R8 5-0 borrow", int'(c0), 0);
    chk("R8 5-0 uns_unf", int'(uu0), 0);

    for (int i = 0; i < 3000; i++) begin
      int ra, rb, rop, rcf;
      @(negedge clk);
      ra = int'($urandom & 32'hFFFF); rb = int'($urandom & 32'hFFFF);
      rop = int'($urandom % 4); rcf = int'($urandom % 2);
      if (i % 8 == 0) rb = ra;
      a1 = ra[15:0]; b1 = rb[15:0]; op1 = rop[1:0]; cf1 = rcf[0];
      model(16, ra, rb, rop, rcf, er, ec, en, ez, ev, eo, eu);
      #5;
      chk(rtag(rop), int'(r1), er);
      chk("R5 c_flag w16", int'(c1), ec);
      chk("R5 uns w16", int'({uo1, uu1}), eo * 2 + eu);
      chk("R6 v_flag w16", int'(v1), ev);
      chk("R7 n/z w16", int'({n1, z1}), en * 2 + ez);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule